// File: doc/BRIEF.md
# Quad-channel UART register access over SPI

This block is an SPI target that lets a host reach the byte-wide control registers of four identical UART channels. Every frame is sixteen bits: an address byte followed by a data byte, both shifted most significant bit first. The address byte holds a direction flag, a channel field and a register offset, so the four channel register files sit at a fixed stride of 0x10 in one small address space.

The SPI pins are oversampled in the system clock domain, so all state lives on `clk`. A completed write frame produces a one-cycle strobe carrying channel, offset and data for the UART datapaths. The same strobe also updates the per-channel registers kept inside the block: the interrupt-enable byte, the modem-control byte and a scratch byte that the host uses to test the link. On a read frame, the addressed value is fetched when the address byte completes and is shifted out during the data byte.

Top module: `spi_uart_regif`

## Requirements
- R1: After synchronous reset, `spi_miso` and `wr_stb` are low and every channel's interrupt-enable and modem-control outputs are 0x00.
- R2: The address byte is decoded as bit 7 = 1 for write and 0 for read, bits 6:4 = channel, bits 3:0 = offset. So channel c offset k is written at 0x80+16c+k and read at 16c+k. Both bytes travel MSB first on `spi_mosi` and `spi_miso`.
- R3: Each complete write frame to a valid channel raises `wr_stb` for exactly one `clk` cycle, with `wr_chan`, `wr_off` and `wr_data` equal to the frame's channel, offset and data byte.
- R4: Offset 7 of each channel is a scratch byte. A value written there, for example 0x55 or 0x66, reads back unchanged.
- R5: Offset 1 is the interrupt-enable byte and offset 4 is the modem-control byte. After a write, the value reads back and appears on `ier_flat[8c+7:8c]` or `mcr_flat[8c+7:8c]` for channel c. These outputs change only in the cycle after a strobe to that offset.
- R6: Reads of offsets other than 1, 4 and 7 return 0x00, even after such an offset has been written.
- R7: A write to one channel leaves the registers of the other channels unchanged.
- R8: A read frame produces no strobe and changes no register.
- R9: If `spi_csn` rises before the sixteenth rising SCK edge, the frame is dropped: no strobe and no register change.
- R10: A channel field of 4 or more selects nothing. Writes give no strobe, and reads return 0x00.
- R11: The interface uses SPI mode 3. The target samples `spi_mosi` on rising SCK edges and changes `spi_miso` on falling edges. The first data bit of a read is on `spi_miso` before the ninth rising edge.
- R12: `spi_miso` is low while `spi_csn` is high and throughout the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock, idles high |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_chan | output | 2 | Channel of the write |
| wr_off | output | 4 | Register offset of the write |
| wr_data | output | 8 | Data byte of the write |
| ier_flat | output | 32 | Interrupt-enable bytes, channel c at bits 8c+7:8c |
| mcr_flat | output | 32 | Modem-control bytes, channel c at bits 8c+7:8c |

## Verification
The properties assume that the SCK half period is well above the three-cycle synchroniser and edge-detect latency. They also assume that chip select stays low for some cycles after the last rising edge of a frame, and stays high for at least four cycles between frames. The bench keeps to these limits with a ten-cycle SCK half period, and it waits half a period after the final rising edge before releasing chip select. The abort case raises chip select a half period after the twelfth rising edge, which still gives the synchroniser time to see it cleanly.

// File: rtl/spi_uart_pkg.sv
package spi_uart_pkg;
  localparam int BYTE_W     = 8;
  localparam int OFF_W      = 4;
  localparam int FLD_W      = 3;
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int RW_BIT     = BYTE_W - 1;

  localparam logic [OFF_W-1:0] OFF_IER = 4'd1;
  localparam logic [OFF_W-1:0] OFF_MCR = 4'd4;
  localparam logic [OFF_W-1:0] OFF_SCR = 4'd7;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d_in};
  end

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_uart_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int CHAN_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [FLD_W-1:0]  rd_chan,
  output logic [OFF_W-1:0]  rd_off,
  output logic              wr_stb,
  output logic [CHAN_W-1:0] wr_chan,
  output logic [OFF_W-1:0]  wr_off,
  output logic [BYTE_W-1:0] wr_data,
  output logic              miso
);
  localparam logic [FLD_W:0]   CHAN_LIM   = (FLD_W+1)'(NUM_CHAN);
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL       = CNT_W'(FRAME_BITS);

  logic              sck_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] sh_in;
  logic [BYTE_W-1:0] addr_q;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] nxt;
  logic              sck_rise, sck_fall, chan_ok;

  assign nxt      = {sh_in[BYTE_W-2:0], mosi_s};
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign chan_ok  = {1'b0, addr_q[OFF_W +: FLD_W]} < CHAN_LIM;
  assign rd_chan  = nxt[OFF_W +: FLD_W];
  assign rd_off   = nxt[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d   <= 1'b1;
      bit_cnt <= '0;
      sh_in   <= '0;
      addr_q  <= '0;
      tx_sh   <= '0;
      wr_stb  <= 1'b0;
      wr_chan <= '0;
      wr_off  <= '0;
      wr_data <= '0;
      miso    <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      sck_d  <= sck_s;
      if (csn_s) begin
        bit_cnt <= '0;
        miso    <= 1'b0;
      end else if (sck_rise && bit_cnt != FULL) begin
        sh_in   <= nxt;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == ADDR_LAST) begin
          addr_q <= nxt;
          tx_sh  <= nxt[RW_BIT] ? '0 : rd_data;
        end
        if (bit_cnt == DATA_LAST && addr_q[RW_BIT] && chan_ok) begin
          wr_stb  <= 1'b1;
          wr_chan <= addr_q[OFF_W +: CHAN_W];
          wr_off  <= addr_q[OFF_W-1:0];
          wr_data <= nxt;
        end
      end else if (sck_fall) begin
        if (bit_cnt >= DATA_FIRST && bit_cnt != FULL && !addr_q[RW_BIT]) begin
          miso  <= tx_sh[BYTE_W-1];
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end else if (bit_cnt < DATA_FIRST) begin
          miso <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/chan_reg_bank.sv
module chan_reg_bank
  import spi_uart_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int CHAN_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_stb,
  input  logic [CHAN_W-1:0]            wr_chan,
  input  logic [OFF_W-1:0]             wr_off,
  input  logic [BYTE_W-1:0]            wr_data,
  input  logic [FLD_W-1:0]             rd_chan,
  input  logic [OFF_W-1:0]             rd_off,
  output logic [BYTE_W-1:0]            rd_data,
  output logic [NUM_CHAN*BYTE_W-1:0]   ier_flat,
  output logic [NUM_CHAN*BYTE_W-1:0]   mcr_flat
);
  logic [BYTE_W-1:0] ier_r [NUM_CHAN];
  logic [BYTE_W-1:0] mcr_r [NUM_CHAN];
  logic [BYTE_W-1:0] scr_r [NUM_CHAN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CHAN; c++) begin
        ier_r[c] <= '0;
        mcr_r[c] <= '0;
        scr_r[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CHAN; c++) begin
        if (wr_stb && wr_chan == CHAN_W'(c)) begin
          case (wr_off)
            OFF_IER: ier_r[c] <= wr_data;
            OFF_MCR: mcr_r[c] <= wr_data;
            OFF_SCR: scr_r[c] <= wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if ({1'b0, rd_chan} == (FLD_W+1)'(c)) begin
        case (rd_off)
          OFF_IER: rd_data = ier_r[c];
          OFF_MCR: rd_data = mcr_r[c];
          OFF_SCR: rd_data = scr_r[c];
          default: rd_data = '0;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_flat
    assign ier_flat[g*BYTE_W +: BYTE_W] = ier_r[g];
    assign mcr_flat[g*BYTE_W +: BYTE_W] = mcr_r[g];
  end
endmodule

// File: rtl/spi_uart_regif.sv
module spi_uart_regif
  import spi_uart_pkg::*;
#(
  parameter int NUM_CHAN    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CHAN_W     = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       spi_sck,
  input  logic                       spi_csn,
  input  logic                       spi_mosi,
  output logic                       spi_miso,
  output logic                       wr_stb,
  output logic [CHAN_W-1:0]          wr_chan,
  output logic [OFF_W-1:0]           wr_off,
  output logic [BYTE_W-1:0]          wr_data,
  output logic [NUM_CHAN*BYTE_W-1:0] ier_flat,
  output logic [NUM_CHAN*BYTE_W-1:0] mcr_flat
);
  logic [2:0]        pins_s;
  logic [FLD_W-1:0]  rd_chan;
  logic [OFF_W-1:0]  rd_off;
  logic [BYTE_W-1:0] rd_data;

  spi_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({spi_mosi, spi_csn, spi_sck}),
    .q_out (pins_s)
  );

  spi_frame_ctrl #(.NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .sck_s   (pins_s[0]),
    .csn_s   (pins_s[1]),
    .mosi_s  (pins_s[2]),
    .rd_data (rd_data),
    .rd_chan (rd_chan),
    .rd_off  (rd_off),
    .wr_stb  (wr_stb),
    .wr_chan (wr_chan),
    .wr_off  (wr_off),
    .wr_data (wr_data),
    .miso    (spi_miso)
  );

  chan_reg_bank #(.NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_stb),
    .wr_chan  (wr_chan),
    .wr_off   (wr_off),
    .wr_data  (wr_data),
    .rd_chan  (rd_chan),
    .rd_off   (rd_off),
    .rd_data  (rd_data),
    .ier_flat (ier_flat),
    .mcr_flat (mcr_flat)
  );
endmodule

// File: rtl/spi_uart_regif_chk.sv
module spi_uart_regif_chk
  import spi_uart_pkg::*;
#(
  parameter int NUM_CHAN = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       spi_csn,
  input logic                       spi_miso,
  input logic                       wr_stb,
  input logic [OFF_W-1:0]           wr_off,
  input logic [NUM_CHAN*BYTE_W-1:0] ier_flat,
  input logic [NUM_CHAN*BYTE_W-1:0] mcr_flat
);
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb); // R3

  AST_STB_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !spi_csn); // R9

  AST_IER_ON_STB: assert property (@(posedge clk) disable iff (rst)
    !$stable(ier_flat) |-> ($past(wr_stb) && $past(wr_off) == OFF_IER)); // R5

  AST_MCR_ON_STB: assert property (@(posedge clk) disable iff (rst)
    !$stable(mcr_flat) |-> ($past(wr_stb) && $past(wr_off) == OFF_MCR)); // R5

  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)
     && $past(spi_csn, 4)) |-> !spi_miso); // R12
endmodule

bind spi_uart_regif spi_uart_regif_chk #(.NUM_CHAN(NUM_CHAN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .spi_csn  (spi_csn),
  .spi_miso (spi_miso),
  .wr_stb   (wr_stb),
  .wr_off   (wr_off),
  .ier_flat (ier_flat),
  .mcr_flat (mcr_flat)
);

// File: tb/spi_uart_regif_bench.sv
`timescale 1ns/1ps
module spi_uart_regif_bench;
  localparam int NUM_CHAN = 4;
  localparam int HALF     = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b1;
  logic spi_csn = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso;
  logic wr_stb;
  logic [1:0]  wr_chan;
  logic [3:0]  wr_off;
  logic [7:0]  wr_data;
  logic [31:0] ier_flat;
  logic [31:0] mcr_flat;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [13:0] exp_q[$];

  always #10 clk = ~clk;

  spi_uart_regif #(.NUM_CHAN(NUM_CHAN)) u_spi_uart_regif (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .wr_stb(wr_stb),
    .wr_chan(wr_chan), .wr_off(wr_off), .wr_data(wr_data),
    .ier_flat(ier_flat), .mcr_flat(mcr_flat)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for write strobes (R3)
  always @(negedge clk) begin
    if (!rst && wr_stb) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected strobe", {18'd0, wr_chan, wr_off, wr_data}, 32'h0);
      end else begin
        logic [13:0] e;
        e = exp_q.pop_front();
        chk({wr_chan, wr_off, wr_data} == e, "R3 strobe fields",
            {18'd0, wr_chan, wr_off, wr_data}, {18'd0, e});
      end
    end
  end

  task automatic spi_xfer(input logic [7:0] a, input logic [7:0] d, input int nbits,
                          output logic [7:0] rd, output bit addr_bad);
    rd = '0;
    addr_bad = 1'b0;
    @(negedge clk) spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_sck  = 1'b0;
      spi_mosi = (i < 8) ? a[7-i] : d[15-i];
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      if (i >= 8) rd[15-i] = spi_miso;
      else if (spi_miso) addr_bad = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    spi_csn = 1'b1;
    repeat (3*HALF) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit stb_exp,
                          input string tag);
    logic [7:0] rd;
    bit bad;
    if (stb_exp) exp_q.push_back({a[5:4], a[3:0], d});
    spi_xfer(a, d, 16, rd, bad);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] rd;
    bit bad;
    spi_xfer(a, 8'h00, 16, rd, bad);
    chk(rd == exp, tag, rd, exp);
    chk(!bad, "R12 miso low in address byte", bad, 0);
  endtask

  initial begin
    logic [7:0] rd;
    bit bad;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(spi_miso == 1'b0, "R1 miso after reset", spi_miso, 0);
    chk(wr_stb == 1'b0, "R1 strobe after reset", wr_stb, 0);
    chk(ier_flat == 32'h0 && mcr_flat == 32'h0, "R1 regs after reset", ier_flat | mcr_flat, 0);

    // R4 R2 scratch with link test patterns, MSB first
    do_write(8'h87, 8'h55, 1'b1, "R3 write scr ch0 0x55");
    do_read(8'h07, 8'h55, "R4 R11 scratch ch0 0x55");
    do_write(8'h87, 8'h66, 1'b1, "R3 write scr ch0 0x66");
    do_read(8'h07, 8'h66, "R4 scratch ch0 0x66");

    // R7 distinct scratch per channel
    do_write(8'h97, 8'hA1, 1'b1, "R3 write scr ch1");
    do_write(8'hA7, 8'h3C, 1'b1, "R3 write scr ch2");
    do_write(8'hB7, 8'h81, 1'b1, "R3 write scr ch3");
    do_read(8'h07, 8'h66, "R7 ch0 scratch kept");
    do_read(8'h17, 8'hA1, "R7 ch1 scratch");
    do_read(8'h27, 8'h3C, "R7 ch2 scratch");
    do_read(8'h37, 8'h81, "R7 ch3 scratch");

    // R5 interrupt-enable and modem-control
    do_write(8'h91, 8'h0F, 1'b1, "R3 write ier ch1");
    chk(ier_flat[15:8] == 8'h0F, "R5 ier_flat ch1", ier_flat[15:8], 8'h0F);
    chk(ier_flat[7:0] == 8'h00 && ier_flat[31:16] == 16'h0, "R7 ier other chans", ier_flat, 32'h0F00);
    do_write(8'hA4, 8'hC3, 1'b1, "R3 write mcr ch2");
    chk(mcr_flat[23:16] == 8'hC3, "R5 mcr_flat ch2", mcr_flat[23:16], 8'hC3);
    do_read(8'h11, 8'h0F, "R5 ier ch1 readback");
    do_read(8'h24, 8'hC3, "R5 mcr ch2 readback");
    do_read(8'h21, 8'h00, "R7 ier ch2 untouched");

    // R6 unimplemented offsets
    do_read(8'h06, 8'h00, "R6 offset 6 reads zero");
    do_write(8'h86, 8'hAA, 1'b1, "R3 write offset 6 strobes");
    do_read(8'h06, 8'h00, "R6 offset 6 after write");
    do_read(8'h0F, 8'h00, "R6 offset 15 reads zero");

    // R8 read frame has no side effect (monitor flags any strobe)
    do_read(8'h37, 8'h81, "R8 repeat read ch3");
    do_read(8'h37, 8'h81, "R8 ch3 unchanged by read");

    // R9 abort after 12 bits
    spi_xfer(8'h87, 8'hFF, 12, rd, bad);
    chk(exp_q.size() == 0, "R9 abort no strobe", exp_q.size(), 0);
    do_read(8'h07, 8'h66, "R9 scratch unchanged after abort");
    chk(spi_miso == 1'b0, "R12 miso low with cs high", spi_miso, 0);

    // R10 out-of-range channel
    do_write(8'hC8, 8'hCD, 1'b0, "R10 write ch4 no strobe");
    do_write(8'hC7, 8'hEE, 1'b0, "R10 write ch4 scratch no strobe");
    do_read(8'h47, 8'h00, "R10 read ch4 zero");
    do_read(8'h07, 8'h66, "R10 ch0 unaffected");

    // R11 pattern with alternating bits
    do_write(8'hB4, 8'h5A, 1'b1, "R3 write mcr ch3");
    do_read(8'h34, 8'h5A, "R11 R2 mcr ch3 bit order");

    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule